// File: doc/BRIEF.md
# Cache Line Ownership Bit Array

This block keeps two state bits, Owner and Shared, for each line of a small cache. A one-hot line select picks the line that the current control pulses act on. Bus-side controls set or clear Owner, separate controls set or clear Shared, and a registered processor-write flag lets a processor write claim ownership of the selected line, provided that line is not shared.

The same select is forwarded toward the data RAM. While a processor write is in progress, the select for a shared line is forced to 0, so the write never reaches a line that other caches may hold. A read latch samples the Owner and Shared bits of the selected line on request and holds them for the interface, while the array underneath keeps changing.

Top module: `own_bit_array`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every Owner and Shared bit, the read latch (`own_out`, `shr_out` read 0) and the write flag (`pwip_out` reads 0).
- R2: `bus_set_own` high at an edge sets the Owner bit of the line whose `sel_in` bit is 1 (bit i selects line i). The bit then holds at 1 until it is cleared.
- R3: `bus_clr_own` high at an edge clears the Owner bit of the selected line. The bit then holds at 0 until it is set.
- R4: `set_shr` and `clr_shr` set and clear the Shared bit of the selected line, and that bit holds between writes.
- R5: If a set and a clear of the same bit are both high at one edge, the bit becomes 0.
- R6: `ld_rd` high at an edge loads `own_out`/`shr_out` with the selected line's bits as they stood just before that edge. Without `ld_rd`, the latch keeps its value while the array changes.
- R7: `pwip_out` is a register that takes the value of `pwip_in` at each edge, so it lags that input by one cycle.
- R8: While `pwip_out` is 0, `sel_out` equals `sel_in` combinationally.
- R9: While `pwip_out` is 1, a selected line whose Shared bit is 0 has its Owner bit set at the edge, and its `sel_out` bit follows `sel_in`.
- R10: While `pwip_out` is 1, a selected line whose Shared bit is 1 keeps its Owner bit unchanged by the processor write, and its `sel_out` bit is 0.
- R11: With `sel_in` all zero, no Owner or Shared bit changes, whatever the controls do, and `sel_out` is 0.
- R12: Lines whose select bit is 0 are not changed by controls aimed at another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_in | input | LINES | One-hot line select, bit i is line i |
| pwip_in | input | 1 | Processor write in progress request |
| bus_set_own | input | 1 | Set Owner of the selected line |
| bus_clr_own | input | 1 | Clear Owner of the selected line |
| set_shr | input | 1 | Set Shared of the selected line |
| clr_shr | input | 1 | Clear Shared of the selected line |
| ld_rd | input | 1 | Load the read latch from the selected line |
| own_out | output | 1 | Latched Owner bit |
| shr_out | output | 1 | Latched Shared bit |
| pwip_out | output | 1 | Registered processor write flag |
| sel_out | output | LINES | Line select toward the data RAM |

## Verification
The assertions take for granted that `sel_in` is one-hot or zero, so that the read latch and the RAM select refer to exactly one line. They also assume that the controls are sampled only at rising edges. The bench changes `sel_in` and every control on the falling edge and always drives a single select bit or none. It observes the array only through the read latch, by selecting one line and pulsing `ld_rd`. Processor-write cases first raise `pwip_in` for one cycle with no select. The select is applied only after `pwip_out` has gone high.

// File: rtl/own_pkg.sv
package own_pkg;
    typedef struct packed {
        logic own;
        logic shr;
    } line_bits_t;
endpackage

// File: rtl/own_line_cell.sv
module own_line_cell
    import own_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic pwip,
    input  logic bus_set_own,
    input  logic bus_clr_own,
    input  logic set_shr,
    input  logic clr_shr,
    output logic own,
    output logic shr
);
    line_bits_t st_d, st_q;
    logic       claim;

    always_comb begin
        st_d  = st_q;
        claim = pwip && !st_q.shr;
        if (sel) begin
            if (bus_clr_own)
                st_d.own = 1'b0;
            else if (bus_set_own || claim)
                st_d.own = 1'b1;
            if (clr_shr)
                st_d.shr = 1'b0;
            else if (set_shr)
                st_d.shr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign own = st_q.own;
    assign shr = st_q.shr;

    // R5: clear dominates set
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (sel && bus_clr_own) |=> !own);
    // R10: a shared line is not claimed by a processor write
    a_r10_shared_no_claim: assert property (@(posedge clk) disable iff (rst)
        (sel && pwip && shr && !own && !bus_set_own) |=> !own);
    // R11: an unselected line holds
    a_r11_unsel_hold: assert property (@(posedge clk) disable iff (rst)
        !sel |=> ($stable(own) && $stable(shr)));
endmodule

// File: rtl/own_sel_gate.sv
module own_sel_gate #(
    parameter int LINES = 4
) (
    input  logic [LINES-1:0] sel_in,
    input  logic [LINES-1:0] shr_vec,
    input  logic             pwip,
    output logic [LINES-1:0] sel_out
);
    always_comb begin
        sel_out = sel_in;
        if (pwip)
            sel_out = sel_in & ~shr_vec;
    end
endmodule

// File: rtl/own_rd_latch.sv
module own_rd_latch
    import own_pkg::*;
#(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [LINES-1:0] sel,
    input  logic [LINES-1:0] own_vec,
    input  logic [LINES-1:0] shr_vec,
    output logic             own_out,
    output logic             shr_out
);
    line_bits_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (ld) begin
            lat_d.own = |(sel & own_vec);
            lat_d.shr = |(sel & shr_vec);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            lat_q <= '0;
        else
            lat_q <= lat_d;
    end

    assign own_out = lat_q.own;
    assign shr_out = lat_q.shr;

    // R6: the latch holds without a load
    a_r6_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !ld |=> ($stable(own_out) && $stable(shr_out)));
endmodule

// File: rtl/own_bit_array.sv
module own_bit_array #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] sel_in,
    input  logic             pwip_in,
    input  logic             bus_set_own,
    input  logic             bus_clr_own,
    input  logic             set_shr,
    input  logic             clr_shr,
    input  logic             ld_rd,
    output logic             own_out,
    output logic             shr_out,
    output logic             pwip_out,
    output logic [LINES-1:0] sel_out
);
    logic [LINES-1:0] own_vec;
    logic [LINES-1:0] shr_vec;
    logic             pwip_d, pwip_q;

    always_comb begin
        pwip_d = pwip_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pwip_q <= 1'b0;
        else
            pwip_q <= pwip_d;
    end

    assign pwip_out = pwip_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        own_line_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .sel         (sel_in[i]),
            .pwip        (pwip_q),
            .bus_set_own (bus_set_own),
            .bus_clr_own (bus_clr_own),
            .set_shr     (set_shr),
            .clr_shr     (clr_shr),
            .own         (own_vec[i]),
            .shr         (shr_vec[i])
        );
    end

    own_sel_gate #(.LINES(LINES)) u_gate (
        .sel_in  (sel_in),
        .shr_vec (shr_vec),
        .pwip    (pwip_q),
        .sel_out (sel_out)
    );

    own_rd_latch #(.LINES(LINES)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .ld      (ld_rd),
        .sel     (sel_in),
        .own_vec (own_vec),
        .shr_vec (shr_vec),
        .own_out (own_out),
        .shr_out (shr_out)
    );

    // R7: the flag follows its request one cycle later
    a_r7_flag_rise: assert property (@(posedge clk) disable iff (rst)
        pwip_in |=> pwip_out);
    a_r7_flag_fall: assert property (@(posedge clk) disable iff (rst)
        !pwip_in |=> !pwip_out);
    // R8: the select passes through while no processor write is running
    a_r8_pass_through: assert property (@(posedge clk) disable iff (rst)
        !pwip_out |-> (sel_out == sel_in));
    // R11: no select means no RAM select
    a_r11_idle_select: assert property (@(posedge clk) disable iff (rst)
        (sel_in == '0) |-> (sel_out == '0));
endmodule

// File: tb/own_bit_array_test.sv
module own_bit_array_test;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic [LINES-1:0] sel_in;
    logic             pwip_in, bus_set_own, bus_clr_own, set_shr, clr_shr, ld_rd;
    logic             own_out, shr_out, pwip_out;
    logic [LINES-1:0] sel_out;
    int               total = 0;
    int               bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    own_bit_array #(.LINES(LINES)) uut (
        .clk(clk), .rst(rst), .sel_in(sel_in), .pwip_in(pwip_in),
        .bus_set_own(bus_set_own), .bus_clr_own(bus_clr_own),
        .set_shr(set_shr), .clr_shr(clr_shr), .ld_rd(ld_rd),
        .own_out(own_out), .shr_out(shr_out), .pwip_out(pwip_out),
        .sel_out(sel_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        sel_in = '0; pwip_in = 0; bus_set_own = 0; bus_clr_own = 0;
        set_shr = 0; clr_shr = 0; ld_rd = 0;
    endtask

    task automatic op(input int line, input logic so, input logic co,
                      input logic ss, input logic cs);
        sel_in = LINES'(1 << line);
        bus_set_own = so; bus_clr_own = co; set_shr = ss; clr_shr = cs;
        tick();
        idle();
    endtask

    task automatic read_line(input int line, input int eo, input int es, input string tag);
        sel_in = LINES'(1 << line);
        ld_rd = 1;
        tick();
        idle();
        check({tag, " own"}, own_out, eo);
        check({tag, " shr"}, shr_out, es);
    endtask

    task automatic t_reset();
        check("R1 own_out", own_out, 0);
        check("R1 shr_out", shr_out, 0);
        check("R1 pwip_out", pwip_out, 0);
        for (int i = 0; i < LINES; i++) read_line(i, 0, 0, "R1 line");
        sel_in = 4'b0100; #1;
        check("R8 pass", sel_out, 4);
        idle();
    endtask

    task automatic t_set_clear();
        for (int i = 0; i < LINES; i++) begin
            op(i, 1, 0, 0, 0); read_line(i, 1, 0, "R2 set own");
            op(i, 0, 0, 1, 0); read_line(i, 1, 1, "R4 set shr");
            op(i, 0, 1, 0, 0); read_line(i, 0, 1, "R3 clr own");
            op(i, 0, 0, 0, 1); read_line(i, 0, 0, "R4 clr shr");
        end
    endtask

    task automatic t_clear_wins();
        op(1, 1, 0, 1, 0);
        op(1, 1, 1, 1, 1);
        read_line(1, 0, 0, "R5 both");
    endtask

    task automatic t_latch();
        op(0, 1, 0, 0, 0);
        read_line(0, 1, 0, "R6 load");
        op(0, 0, 1, 1, 0);
        tick();
        check("R6 hold own", own_out, 1);
        check("R6 hold shr", shr_out, 0);
        read_line(0, 0, 1, "R6 reload");
        sel_in = 4'b0001; ld_rd = 1; bus_set_own = 1;
        tick();
        idle();
        check("R6 pre-edge own", own_out, 0);
        read_line(0, 1, 1, "R6 after");
        op(0, 0, 1, 0, 1);
    endtask

    task automatic t_flag();
        pwip_in = 1; #1;
        check("R7 before edge", pwip_out, 0);
        tick();
        check("R7 rise", pwip_out, 1);
        pwip_in = 0;
        tick();
        check("R7 fall", pwip_out, 0);
    endtask

    task automatic t_claim();
        pwip_in = 1; tick();
        sel_in = 4'b0010; pwip_in = 0; #1;
        check("R9 sel_out", sel_out, 2);
        tick(); idle();
        read_line(1, 1, 0, "R9 claim");
        op(1, 0, 1, 0, 0);
    endtask

    task automatic t_shared_block();
        op(2, 0, 0, 1, 0);
        pwip_in = 1; tick();
        sel_in = 4'b0100; pwip_in = 0; #1;
        check("R10 sel_out", sel_out, 0);
        tick(); idle();
        read_line(2, 0, 1, "R10 no claim");
        op(2, 0, 0, 0, 1);
    endtask

    task automatic t_no_select();
        op(3, 1, 0, 0, 0);
        sel_in = '0; bus_set_own = 1; set_shr = 1; #1;
        check("R11 sel_out", sel_out, 0);
        tick(); idle();
        sel_in = '0; bus_clr_own = 1; tick(); idle();
        read_line(0, 0, 0, "R11 line0");
        read_line(3, 1, 0, "R11 line3");
        op(0, 1, 0, 1, 0);
        read_line(3, 1, 0, "R12 other own");
        read_line(2, 0, 0, "R12 other idle");
        read_line(0, 1, 1, "R12 target");
    endtask

    initial begin
        idle();
        rst = 1;
        @(negedge clk); tick();
        rst = 0;
        t_reset();
        t_set_clear();
        t_clear_wins();
        t_latch();
        t_flag();
        t_claim();
        t_shared_block();
        t_no_select();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule